// File: doc/BRIEF.md
# Descriptor Completion Decision Unit

This unit decides what happens when a DMA channel finishes a descriptor. Three decisions are made: whether to raise an interrupt, whether to branch to another descriptor, and whether to hold and wait. Each decision uses its own select register. A select register holds a 4-bit mask and a 4-bit value. These are compared against the 4 low device-status bits, and the result is the decision's condition. A 2-bit mode field from the command word then turns that condition into a yes or a no.

The controller around the unit pulses `eval_i` once per completed descriptor. In that cycle it presents the command's mode bits, the three select registers, the device status, the current command pointer and the branch target taken from the descriptor's command-dependent word. Two outputs answer in the same cycle: the wait flag and the interrupt pulse. The next command pointer and the branch-taken status bit follow one cycle later, marked by `nxt_vld_o`. Descriptor fetch and memory traffic are handled elsewhere.

Top module: `desc_cond_unit`

## Requirements
- R1: For each decision, the condition is true when `(status & mask) == (value & mask)`. Mask is select-register bits 19:16, value is bits 3:0, and status is `dev_stat_i`. All other select-register bits have no effect.
- R2: Each mode field is decoded as 0 = never, 1 = when the condition is true, 2 = when the condition is false, 3 = always. The interrupt mode is `cmd_ctl_i[5:4]`, the branch mode is `cmd_ctl_i[3:2]` and the wait mode is `cmd_ctl_i[1:0]`.
- R3: The interrupt decision uses only `intr_sel_i`, the branch decision uses only `br_sel_i`, and the wait decision uses only `wait_sel_i`.
- R4: `wait_o` is high exactly in a cycle with `eval_i` high and a true wait decision. It is low whenever `eval_i` is low.
- R5: `intr_pulse_o` is high for exactly the cycle of `eval_i`, and only when the wait decision is false and the interrupt decision is true.
- R6: An accepted evaluation (eval without wait) with a true branch decision gives, on the next cycle, `nxt_ptr_o` = the `br_target_i` that was sampled, `bt_o` = 1 and `nxt_vld_o` = 1.
- R7: An accepted evaluation with a false branch decision gives, on the next cycle, `nxt_ptr_o` = the sampled `cur_ptr_i` + 16, `bt_o` = 0 and `nxt_vld_o` = 1.
- R8: An evaluation with a true wait decision raises no interrupt. It leaves `nxt_vld_o` low on the next cycle, and `nxt_ptr_o` and `bt_o` keep their values.
- R9: `nxt_vld_o` is high only on the cycle after an accepted evaluation. Between accepted evaluations, `nxt_ptr_o` and `bt_o` hold their values whatever `cur_ptr_i` and `br_target_i` do.
- R10: While `rst_n` is low at a clock edge, `nxt_ptr_o`, `bt_o` and `nxt_vld_o` clear to zero.
- R11: The sequential pointer advance wraps modulo 2^32, so 0xFFFFFFF0 advances to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_i | input | 1 | Evaluate strobe for a completed descriptor |
| cmd_ctl_i | input | 6 | Interrupt, branch and wait mode fields |
| intr_sel_i | input | 32 | Interrupt select register (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch select register |
| wait_sel_i | input | 32 | Wait select register |
| dev_stat_i | input | 4 | Low device-status bits |
| cur_ptr_i | input | 32 | Current command pointer |
| br_target_i | input | 32 | Branch target from the command-dependent word |
| intr_pulse_o | output | 1 | Single-cycle interrupt request |
| wait_o | output | 1 | Descriptor must wait |
| nxt_ptr_o | output | 32 | Next command pointer |
| bt_o | output | 1 | Branch-taken status bit |
| nxt_vld_o | output | 1 | Next pointer and branch-taken bit are valid |

## Verification
The bench aims at these corner cases:
- **Mode decode.** It runs each mode code against both condition outcomes. A swapped or mis-decoded mode would raise interrupts or branches on the inverted condition.
- **Ignored select bits.** It fills the unused select-register bits with ones and lets status bits outside the mask differ from the value. A compare that used the full field, or the wrong select register, would then flip the decision.
- **Wait.** It checks that a waiting evaluation suppresses both the interrupt and the pointer update. A unit that ignored the wait would advance past a descriptor that must stay.
- **Pointer hold and wrap.** It changes the pointer inputs while no evaluation is pending, and it advances from the top of the address space. A unit without a proper hold, or with a carry error, would show a wrong next pointer.

// File: rtl/desc_cond_pkg.sv
// Package: shared types for the descriptor completion decision unit.
// Assumes: mode encoding of 2 bits, fixed by the command word format.
package desc_cond_pkg;

    typedef enum logic [1:0] {
        MODE_NEVER    = 2'd0,
        MODE_IF_TRUE  = 2'd1,
        MODE_IF_FALSE = 2'd2,
        MODE_ALWAYS   = 2'd3
    } cond_mode_e;

    // Decision slots; the field of slot g sits at bits 2*(NUM_DEC-1-g)+:2
    localparam int DEC_INTR   = 0;
    localparam int DEC_BRANCH = 1;
    localparam int DEC_WAIT   = 2;
    localparam int NUM_DEC    = 3;

endpackage

// File: rtl/desc_cond_match.sv
// Module: masked status compare for one decision.
// Does: reports whether the masked status equals the masked value.
// Assumes: mask and value were already sliced from the select register.
module desc_cond_match #(
    parameter int STAT_W = 4
) (
    input  logic [STAT_W-1:0] mask_i,
    input  logic [STAT_W-1:0] val_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              match_o
);

    // Compare only the bits the mask selects
    always_comb begin
        match_o = ((stat_i & mask_i) == (val_i & mask_i));
    end

endmodule

// File: rtl/desc_cond_mode.sv
// Module: applies a 2-bit mode to a condition.
// Does: turns never / if-true / if-false / always into a single decision.
// Assumes: the mode field is stable while it is being evaluated.
module desc_cond_mode
    import desc_cond_pkg::*;
(
    input  cond_mode_e mode_i,
    input  logic       cond_i,
    output logic       fire_o
);

    // Mode decode
    always_comb begin
        unique case (mode_i)
            MODE_NEVER:    fire_o = 1'b0;
            MODE_IF_TRUE:  fire_o = cond_i;
            MODE_IF_FALSE: fire_o = ~cond_i;
            MODE_ALWAYS:   fire_o = 1'b1;
            default:       fire_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/desc_cond_ptr.sv
// Module: next command pointer and branch-taken register.
// Does: on load, captures the branch target (take) or pointer+STEP, and
//       flags the result valid for one cycle; otherwise holds.
// Assumes: synchronous active-low reset; arithmetic wraps at PTR_W bits.
module desc_cond_ptr #(
    parameter int PTR_W = 32,
    parameter int STEP  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             take_i,
    input  logic [PTR_W-1:0] cur_i,
    input  logic [PTR_W-1:0] tgt_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             bt_o,
    output logic             vld_o
);

    localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

    logic [PTR_W-1:0] seq_ptr;

    // Sequential successor of the current descriptor
    always_comb begin
        seq_ptr = cur_i + STEP_V;
    end

    // Register the chosen pointer and branch-taken bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
            bt_o  <= 1'b0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= load_i;
            if (load_i) begin
                ptr_o <= take_i ? tgt_i : seq_ptr;
                bt_o  <= take_i;
            end
        end
    end

endmodule

// File: rtl/desc_cond_unit.sv
// Module: descriptor completion decision unit (top).
// Does: evaluates the interrupt, branch and wait decisions for a completed
//       descriptor, pulses the interrupt, flags a wait, and registers the
//       next command pointer with its branch-taken bit.
// Assumes: eval_i is a one-cycle strobe; all inputs are valid with it.
module desc_cond_unit
    import desc_cond_pkg::*;
#(
    parameter int PTR_W     = 32,
    parameter int SEL_W     = 32,
    parameter int STAT_W    = 4,
    parameter int MASK_LSB  = 16,
    parameter int DESC_BYTES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eval_i,
    input  logic [2*NUM_DEC-1:0] cmd_ctl_i,
    input  logic [SEL_W-1:0]     intr_sel_i,
    input  logic [SEL_W-1:0]     br_sel_i,
    input  logic [SEL_W-1:0]     wait_sel_i,
    input  logic [STAT_W-1:0]    dev_stat_i,
    input  logic [PTR_W-1:0]     cur_ptr_i,
    input  logic [PTR_W-1:0]     br_target_i,
    output logic                 intr_pulse_o,
    output logic                 wait_o,
    output logic [PTR_W-1:0]     nxt_ptr_o,
    output logic                 bt_o,
    output logic                 nxt_vld_o
);

    localparam logic [SEL_W-1:0] FIELD_ONES = SEL_W'((1 << STAT_W) - 1);
    localparam logic [SEL_W-1:0] USED_BITS  = FIELD_ONES | (FIELD_ONES << MASK_LSB);

    logic [SEL_W-1:0]   sel_arr [NUM_DEC];
    logic [NUM_DEC-1:0] cond;
    logic [NUM_DEC-1:0] fire;
    logic               accept;
    logic               unused_sel;

    // Route each select register to its decision slot
    always_comb begin
        sel_arr[DEC_INTR]   = intr_sel_i;
        sel_arr[DEC_BRANCH] = br_sel_i;
        sel_arr[DEC_WAIT]   = wait_sel_i;
    end

    // Bits outside the mask and value fields carry no meaning here
    assign unused_sel = ^((intr_sel_i | br_sel_i | wait_sel_i) & ~USED_BITS);

    generate
        for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
            localparam int FLD_LSB = 2 * (NUM_DEC - 1 - g);
            cond_mode_e mode;

            // Extract this decision's mode field
            always_comb begin
                mode = cond_mode_e'(cmd_ctl_i[FLD_LSB +: 2]);
            end

            desc_cond_match #(.STAT_W(STAT_W)) u_match (
                .mask_i  (sel_arr[g][MASK_LSB +: STAT_W]),
                .val_i   (sel_arr[g][STAT_W-1:0]),
                .stat_i  (dev_stat_i),
                .match_o (cond[g])
            );

            desc_cond_mode u_mode (
                .mode_i (mode),
                .cond_i (cond[g]),
                .fire_o (fire[g])
            );
        end
    endgenerate

    // A waiting descriptor neither interrupts nor moves the pointer
    always_comb begin
        wait_o       = eval_i & fire[DEC_WAIT];
        accept       = eval_i & ~fire[DEC_WAIT];
        intr_pulse_o = accept & fire[DEC_INTR];
    end

    desc_cond_ptr #(.PTR_W(PTR_W), .STEP(DESC_BYTES)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .take_i (fire[DEC_BRANCH]),
        .cur_i  (cur_ptr_i),
        .tgt_i  (br_target_i),
        .ptr_o  (nxt_ptr_o),
        .bt_o   (bt_o),
        .vld_o  (nxt_vld_o)
    );

endmodule

// File: rtl/desc_cond_unit_chk.sv
// Module: property checker for desc_cond_unit, attached by bind.
// Does: checks timing relations between strobe, wait, interrupt and the
//       registered pointer outputs.
// Assumes: synchronous active-low reset.
module desc_cond_unit_chk #(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eval_i,
    input logic [PTR_W-1:0] cur_ptr_i,
    input logic [PTR_W-1:0] br_target_i,
    input logic             intr_pulse_o,
    input logic             wait_o,
    input logic [PTR_W-1:0] nxt_ptr_o,
    input logic             bt_o,
    input logic             nxt_vld_o
);

    logic prev_acc;

    // Remember whether the previous cycle held an accepted evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) prev_acc <= 1'b0;
        else        prev_acc <= eval_i & ~wait_o;
    end

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |-> (!wait_o && !intr_pulse_o));

    assert_intr_only_accepted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        intr_pulse_o |-> (eval_i && !wait_o));

    assert_branch_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_acc && nxt_vld_o && bt_o) |-> (nxt_ptr_o == $past(br_target_i)));

    assert_seq_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_acc && nxt_vld_o && !bt_o) |->
            (nxt_ptr_o == $past(cur_ptr_i) + PTR_W'(DESC_BYTES)));

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(eval_i && !wait_o) |=> ($stable(nxt_ptr_o) && $stable(bt_o)));

    assert_valid_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_vld_o == prev_acc);

endmodule

bind desc_cond_unit desc_cond_unit_chk #(
    .PTR_W      (PTR_W),
    .DESC_BYTES (DESC_BYTES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .eval_i       (eval_i),
    .cur_ptr_i    (cur_ptr_i),
    .br_target_i  (br_target_i),
    .intr_pulse_o (intr_pulse_o),
    .wait_o       (wait_o),
    .nxt_ptr_o    (nxt_ptr_o),
    .bt_o         (bt_o),
    .nxt_vld_o    (nxt_vld_o)
);

// File: tb/desc_cond_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the decision unit, compared each cycle.
module desc_cond_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        eval_i;
    logic [5:0]  cmd_ctl_i;
    logic [31:0] intr_sel_i, br_sel_i, wait_sel_i;
    logic [3:0]  dev_stat_i;
    logic [31:0] cur_ptr_i, br_target_i;
    logic        intr_pulse_o, wait_o, bt_o, nxt_vld_o;
    logic [31:0] nxt_ptr_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_ptr = '0;
    logic        exp_bt  = 1'b0;
    logic        exp_vld = 1'b0;
    string       prev_tag = "R10";

    always #5 clk = ~clk;

    desc_cond_unit dut_i (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .cmd_ctl_i(cmd_ctl_i),
        .intr_sel_i(intr_sel_i), .br_sel_i(br_sel_i), .wait_sel_i(wait_sel_i),
        .dev_stat_i(dev_stat_i), .cur_ptr_i(cur_ptr_i), .br_target_i(br_target_i),
        .intr_pulse_o(intr_pulse_o), .wait_o(wait_o), .nxt_ptr_o(nxt_ptr_o),
        .bt_o(bt_o), .nxt_vld_o(nxt_vld_o)
    );

    // Reference: masked compare, bit by bit
    function automatic bit ref_cond(logic [31:0] sel, logic [3:0] st);
        for (int i = 0; i < 4; i++)
            if (sel[16+i] && (st[i] != sel[i])) return 1'b0;
        return 1'b1;
    endfunction

    // Reference: mode code applied to condition
    function automatic bit ref_mode(int code, bit c);
        if (code == 0) return 1'b0;
        if (code == 1) return c;
        if (code == 2) return !c;
        return 1'b1;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic chk_regs(string tag);
        chk(tag, "nxt_vld", {31'b0, nxt_vld_o}, {31'b0, exp_vld});
        chk(exp_bt ? {tag, "/R6"} : {tag, "/R7"}, "nxt_ptr", nxt_ptr_o, exp_ptr);
        chk(tag, "bt", {31'b0, bt_o}, {31'b0, exp_bt});
    endtask

    task automatic apply(string tag, bit ev, bit [5:0] ctl, logic [31:0] isel,
                         logic [31:0] bsel, logic [31:0] wsel, bit [3:0] st,
                         logic [31:0] cp, logic [31:0] tg);
        bit wd, id, bd;
        @(negedge clk);
        chk_regs(prev_tag);
        eval_i = ev; cmd_ctl_i = ctl; intr_sel_i = isel; br_sel_i = bsel;
        wait_sel_i = wsel; dev_stat_i = st; cur_ptr_i = cp; br_target_i = tg;
        #1;
        id = ref_mode(int'(ctl[5:4]), ref_cond(isel, st));
        bd = ref_mode(int'(ctl[3:2]), ref_cond(bsel, st));
        wd = ref_mode(int'(ctl[1:0]), ref_cond(wsel, st));
        chk({tag, "/R4"}, "wait", {31'b0, wait_o}, {31'b0, ev && wd});
        chk({tag, "/R5"}, "intr", {31'b0, intr_pulse_o}, {31'b0, ev && !wd && id});
        @(posedge clk);
        if (ev && !wd) begin
            exp_ptr = bd ? tg : cp + 32'd16;
            exp_bt  = bd;
            exp_vld = 1'b1;
        end else begin
            exp_vld = 1'b0;
        end
        prev_tag = tag;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; eval_i = 1'b0; cmd_ctl_i = '0; intr_sel_i = '0;
        br_sel_i = '0; wait_sel_i = '0; dev_stat_i = '0;
        cur_ptr_i = '0; br_target_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk_regs("R10");
        chk("R10", "wait", {31'b0, wait_o}, 32'd0);
        chk("R10", "intr", {31'b0, intr_pulse_o}, 32'd0);
        rst_n = 1'b1;

        // R7: all modes never, sequential advance
        apply("R7", 1, 6'b00_00_00, 0, 0, 0, 4'h0, 32'h0000_0100, 32'h0000_9000);
        // R6: branch always
        apply("R6", 1, 6'b00_11_00, 0, 0, 0, 4'h0, 32'h0000_0200, 32'h0000_2000);
        // R2: if-true with condition true -> interrupt and branch
        apply("R2", 1, 6'b01_01_00, 32'h000F_0005, 32'h000F_0005, 0, 4'h5, 32'h10, 32'h4440);
        // R2: if-false with condition true -> neither
        apply("R2", 1, 6'b10_10_00, 32'h000F_0005, 32'h000F_0005, 0, 4'h5, 32'h20, 32'h5550);
        // R2: if-false with condition false -> both
        apply("R2", 1, 6'b10_10_00, 32'h000F_0005, 32'h000F_0005, 0, 4'h4, 32'h30, 32'h6660);
        // R2: interrupt always, branch never
        apply("R2", 1, 6'b11_00_00, 0, 0, 0, 4'h9, 32'h40, 32'h7770);
        // R1: only masked bits count; unused select bits set high
        apply("R1", 1, 6'b01_01_00, 32'hFFF5_FFF0, 32'hFFFA_FFF8, 0, 4'hA, 32'h50, 32'h8880);
        // R1: a masked bit mismatches
        apply("R1", 1, 6'b01_01_00, 32'h0008_0000, 32'h0001_0000, 0, 4'h9, 32'h60, 32'h9990);
        // R3: interrupt select matches, branch select does not
        apply("R3", 1, 6'b01_01_01, 32'h000F_0003, 32'h000F_000C, 32'h000F_0000, 4'h3, 32'h70, 32'hAAA0);
        // R3: wait select alone decides the wait
        apply("R3", 1, 6'b11_11_01, 32'h000F_0000, 32'h000F_0000, 32'h000F_0003, 4'h3, 32'h80, 32'hBBB0);
        // R8: wait always suppresses interrupt and pointer update
        apply("R8", 1, 6'b11_11_11, 0, 0, 0, 4'h0, 32'h90, 32'hCCC0);
        apply("R8", 1, 6'b11_00_11, 0, 0, 0, 4'h1, 32'hA0, 32'hDDD0);
        // R9: no strobe, inputs move, outputs hold
        apply("R9", 0, 6'b11_11_00, 0, 0, 0, 4'h0, 32'hB0, 32'hEEE0);
        apply("R9", 0, 6'b11_11_00, 0, 0, 0, 4'hF, 32'hC0, 32'hFFF0);
        // R11: wrap of the sequential advance
        apply("R11", 1, 6'b00_00_00, 0, 0, 0, 4'h0, 32'hFFFF_FFF0, 32'h1230);

        // Mixed stimulus across modes and conditions
        for (int k = 0; k < 400; k++) begin
            apply("R2-mix", 1'($urandom_range(0, 3) != 0), 6'($urandom),
                  {12'($urandom), 4'($urandom), 12'($urandom), 4'($urandom)},
                  {12'($urandom), 4'($urandom), 12'($urandom), 4'($urandom)},
                  {12'($urandom), 4'($urandom), 12'($urandom), 4'($urandom)},
                  4'($urandom), $urandom, $urandom);
        end

        @(negedge clk);
        chk_regs(prev_tag);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule